// File: doc/BRIEF.md
# Bidirectional Shift and Storage Register with Shared Parallel Port

This block is a storage register of configurable width (eight stages by default) that can keep its contents, move them one place toward the last stage, move them one place toward the first stage, or capture a full word in parallel. A two-bit mode select picks one of these four operations. All of them act on the rising clock edge. An active-low asynchronous clear empties every stage at once, whatever the clock or the mode select are doing.

The parallel port is shared between capture and read-back. It is modelled as three separate signals: an input word, an output word and a single output enable for the whole bus. A wrapper above the block can merge them onto a bidirectional pad. The bus output enable is high only when both active-low enable inputs are low and the mode is not a parallel capture. A capture therefore always releases the bus so the word on it can be sampled.

Two serial outputs always carry the contents of the first and the last stage. Several instances can be cascaded for longer words: the last-stage output feeds the next instance's first-stage serial input, and the first-stage output feeds back to the previous instance's last-stage serial input.

Top module: `usr_shift_io`

## Requirements
- R1: While rst_ni is low, every stage is 0. The clear takes effect without a clock edge and overrides any mode.
- R2: With mode_i = 2'b00 (hold), a rising edge leaves every stage unchanged.
- R3: With mode_i = 2'b01, a rising edge moves data toward the last stage. Stage 0 takes ser_up_i and stage i takes the old value of stage i-1.
- R4: With mode_i = 2'b10, a rising edge moves data toward the first stage. Stage W-1 takes ser_dn_i and stage i takes the old value of stage i+1.
- R5: With mode_i = 2'b11, a rising edge copies bus_i into the stages, with bit i going to stage i.
- R6: bus_oe_o is 1 exactly when en_a_ni and en_b_ni are both 0 and mode_i is not 2'b11. It is combinational, with no clock delay.
- R7: The enable inputs have no effect on clear, hold, either shift or capture.
- R8: ser_first_o always equals stage 0 and ser_last_o always equals stage W-1, in every mode and at every enable setting.
- R9: bus_o always presents the stage contents, with bit i taken from stage i.
- R10: A clear applied in the middle of a run of shifts empties the register. Shifting after the clear is released starts again from all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| mode_i | input | 2 | 00 hold, 01 shift toward last, 10 shift toward first, 11 parallel capture |
| en_a_ni | input | 1 | Bus output enable A, active low |
| en_b_ni | input | 1 | Bus output enable B, active low |
| ser_up_i | input | 1 | Serial data into stage 0 when shifting toward the last stage |
| ser_dn_i | input | 1 | Serial data into stage W-1 when shifting toward the first stage |
| bus_i | input | W | Word sampled from the shared lines during capture |
| bus_o | output | W | Stage contents driven onto the shared lines |
| bus_oe_o | output | 1 | Drive enable for all shared lines |
| ser_first_o | output | 1 | Stage 0 contents, always driven |
| ser_last_o | output | 1 | Stage W-1 contents, always driven |

## Verification
Each mode is tried with fixed, recognisable words such as alternating bits and a single set bit. A lone bit walked the full length in each direction shows that the serial inputs enter at opposite ends and that no stage is skipped or duplicated. Long runs of randomly chosen modes, serial bits, bus words and enable pairs are then compared every cycle against a queue-based model. This shows that the enables change only the bus drive and never the stored data, and that a capture releases the bus whatever the enables are. A clear dropped in the middle of a shift run, with no clock edge between the drop and the check, separates an asynchronous clear from a synchronous one.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       en_a_ni,
  input  logic       en_b_ni,
  output usr_mode_e  mode_o,
  output logic       bus_oe_o
);
  always_comb begin
    mode_o   = usr_mode_e'(mode_i);
    // capture must release the shared lines
    bus_oe_o = ~en_a_ni & ~en_b_ni & (mode_o != MODE_LOAD);
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  usr_mode_e mode_i,
  input  logic      from_lo_i,
  input  logic      from_hi_i,
  input  logic      par_i,
  output logic      q_o
);
  logic d;

  always_comb begin
    unique case (mode_i)
      MODE_UP:   d = from_lo_i;
      MODE_DN:   d = from_hi_i;
      MODE_LOAD: d = par_i;
      default:   d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d;
  end
endmodule

// File: rtl/usr_shift_io.sv
module usr_shift_io
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         en_a_ni,
  input  logic         en_b_ni,
  input  logic         ser_up_i,
  input  logic         ser_dn_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] bus_o,
  output logic         bus_oe_o,
  output logic         ser_first_o,
  output logic         ser_last_o
);
  localparam int LAST = W - 1;

  usr_mode_e    mode;
  logic [W-1:0] q;
  logic [W-1:0] lo_nbr;
  logic [W-1:0] hi_nbr;

  usr_ctrl u_ctrl (
    .mode_i  (mode_i),
    .en_a_ni (en_a_ni),
    .en_b_ni (en_b_ni),
    .mode_o  (mode),
    .bus_oe_o(bus_oe_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_lo_end
      assign lo_nbr[i] = ser_up_i;
    end else begin : g_lo_mid
      assign lo_nbr[i] = q[i-1];
    end
    if (i == LAST) begin : g_hi_end
      assign hi_nbr[i] = ser_dn_i;
    end else begin : g_hi_mid
      assign hi_nbr[i] = q[i+1];
    end

    usr_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mode_i   (mode),
      .from_lo_i(lo_nbr[i]),
      .from_hi_i(hi_nbr[i]),
      .par_i    (bus_i[i]),
      .q_o      (q[i])
    );
  end

  assign bus_o       = q;
  assign ser_first_o = q[0];
  assign ser_last_o  = q[LAST];
endmodule

// File: rtl/usr_shift_io_chk.sv
module usr_shift_io_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   mode_i,
  input logic         en_a_ni,
  input logic         en_b_ni,
  input logic         ser_up_i,
  input logic         ser_dn_i,
  input logic [W-1:0] bus_i,
  input logic [W-1:0] bus_o,
  input logic         bus_oe_o,
  input logic         ser_first_o,
  input logic         ser_last_o
);
  p_clear_r1: assert property (@(posedge clk_i) !rst_ni |-> bus_o == '0);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> $stable(bus_o));

  p_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b01 |=> bus_o == {$past(bus_o[W-2:0]), $past(ser_up_i)});

  p_dn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> bus_o == {$past(ser_dn_i), $past(bus_o[W-1:1])});

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |=> bus_o == $past(bus_i));

  p_oe_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b11 |-> !bus_oe_o);

  p_oe_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_a_ni || en_b_ni) |-> !bus_oe_o);

  p_oe_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_a_ni && !en_b_ni && mode_i != 2'b11) |-> bus_oe_o);

  p_serial_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_first_o == bus_o[0] && ser_last_o == bus_o[W-1]);
endmodule

bind usr_shift_io usr_shift_io_chk #(.W(W)) u_chk (.*);

// File: tb/sim_usr_shift_io.sv
module sim_usr_shift_io;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic         en_a_ni = 1'b0, en_b_ni = 1'b0;
  logic         ser_up_i = 1'b0, ser_dn_i = 1'b0;
  logic [W-1:0] bus_i = '0;
  logic [W-1:0] bus_o;
  logic         bus_oe_o, ser_first_o, ser_last_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  bit model_q[$];

  always #5 clk_i = ~clk_i;

  usr_shift_io #(.W(W)) u0 (.*);

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model_q[i];
    return v;
  endfunction

  task automatic model_clear();
    model_q.delete();
    for (int i = 0; i < W; i++) model_q.push_back(1'b0);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_state(string req);
    logic [W-1:0] e;
    e = model_word();
    chk(req, bus_o, e);
    chk("R8", {ser_last_o, ser_first_o}, {e[W-1], e[0]});
  endtask

  // starts and ends at a falling edge
  task automatic cyc(logic [1:0] m, logic ea, logic eb, logic su, logic sd,
                     logic [W-1:0] b, string req);
    mode_i = m; en_a_ni = ea; en_b_ni = eb;
    ser_up_i = su; ser_dn_i = sd; bus_i = b;
    #1;
    chk("R6", bus_oe_o, !ea && !eb && m != 2'b11);
    @(posedge clk_i);
    case (m)
      2'b01: begin model_q.push_front(su); void'(model_q.pop_back()); end
      2'b10: begin model_q.push_back(sd); void'(model_q.pop_front()); end
      2'b11: for (int i = 0; i < W; i++) model_q[i] = b[i];
      default: ;
    endcase
    @(negedge clk_i);
    chk_state(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    mode_i = 2'b11;
    repeat (2) @(negedge clk_i);
    chk_state("R1");
    rst_ni = 1'b1;

    // R5 capture, R9 read back
    cyc(2'b11, 0, 0, 0, 0, 8'hA5, "R5");
    cyc(2'b00, 0, 0, 1, 1, 8'h00, "R9");
    // R2 hold with toggling inputs
    cyc(2'b00, 1, 0, 1, 0, 8'hFF, "R2");
    // R3 walk a single bit across
    cyc(2'b11, 0, 0, 0, 0, 8'h00, "R5");
    cyc(2'b01, 0, 0, 1, 0, 8'h00, "R3");
    for (int i = 0; i < W; i++) cyc(2'b01, 0, 1, 0, 1, 8'h00, "R3");
    // R4 walk a single bit back
    cyc(2'b10, 0, 0, 0, 1, 8'h00, "R4");
    for (int i = 0; i < W; i++) cyc(2'b10, 1, 1, 1, 0, 8'h00, "R4");
    // R7 capture and shift with outputs disabled
    cyc(2'b11, 1, 1, 0, 0, 8'h3C, "R7");
    cyc(2'b01, 1, 0, 1, 0, 8'h00, "R7");
    cyc(2'b10, 0, 1, 0, 1, 8'h00, "R7");

    // R10 clear in the middle of a shift run
    cyc(2'b11, 0, 0, 0, 0, 8'hFF, "R5");
    cyc(2'b01, 0, 0, 1, 0, 8'h00, "R3");
    mode_i = 2'b01; ser_up_i = 1'b1;
    rst_ni = 1'b0; #1;
    model_clear();
    chk_state("R1");
    @(negedge clk_i);
    chk_state("R10");
    rst_ni = 1'b1;
    cyc(2'b01, 0, 0, 1, 0, 8'h00, "R10");
    cyc(2'b01, 0, 0, 0, 0, 8'h00, "R10");

    // random mix against the model
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      cyc(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          W'($urandom), m == 2'b11 ? "R5" : (m == 2'b00 ? "R2" : "R7"));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule